// File: doc/BRIEF.md
# ARP Responder with Learned Address Cache

This block resolves IPv4 addresses to Ethernet MAC addresses for one station whose MAC and IP are fixed when the block is built. It listens to a received frame stream and answers any ARP request that asks for the local IP. It also records the sender IP/MAC pair of every well-formed ARP request or reply in a 16-entry cache.

Transmit logic elsewhere in the chip resolves a destination through a lookup port. It presents an IP and gets back a hit flag and a MAC exactly one cycle later. When the lookup misses, the block sends a broadcast ARP request for that IP, so that the answer can be learned. The lookup still reports the miss.

Both frame streams are 16 bits wide with a valid/ready handshake. The first word of each frame is its length in bytes. The data words follow it, most significant byte first, and a final odd byte sits in the high half of its word. Frames that are not ARP are consumed and dropped.

Top module: `arp_responder`

## Requirements
- R1: A received frame with EtherType 0x0806, hardware type 1, protocol type 0x0800, size word 0x0604, opcode 1 and a target IP equal to the local IP produces one reply frame of 31 words. Word 0 holds 60. The data words are: destination MAC = requester MAC, source MAC = local MAC, 0x0806, 0x0001, 0x0800, 0x0604, opcode 2, local MAC, local IP, requester MAC, requester IP, then zero words up to 60 bytes.
- R2: A frame that fails any field test of R1 produces no output frame. A non-ARP frame, or one whose hardware type, protocol type or size word is wrong, is not learned.
- R3: A frame of L bytes is followed by ceil(L/2) data words. An odd L consumes the padded last word, and the next frame is still parsed from its length word.
- R4: A frame with fewer than 21 data words produces no reply and is not learned.
- R5: Each frame that passes the field tests with opcode 1 or 2 stores its sender IP and sender MAC in the cache, whatever its target IP. A later lookup of that IP hits and returns that MAC.
- R6: A lookup presented with lkValid in cycle t gives lkDone high in cycle t+1 only, with lkHit and lkMac valid in that cycle.
- R7: Learning an IP that is already cached overwrites the MAC of that entry and uses no new slot.
- R8: New IPs fill the 16 entries in round-robin order. The 17th distinct IP replaces the oldest insertion.
- R9: A lookup miss queues one ARP request of 31 words. Word 0 holds 60. The data words are: destination ff:ff:ff:ff:ff:ff, source local MAC, 0x0806, 0x0001, 0x0800, 0x0604, opcode 1, local MAC, local IP, zero target MAC, the missed IP, then zero words.
- R10: A miss that arrives while a request is queued or being sent is dropped. Only the first request is sent.
- R11: While txValid is high, rxReady is low. While txValid is high and txReady is low, txData holds its value.
- R12: After reset txValid and lkDone are low, rxReady is high and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxData | input | 16 | Received frame word (length word first) |
| rxValid | input | 1 | rxData is valid |
| rxReady | output | 1 | Block accepts rxData this cycle |
| txData | output | 16 | Transmitted frame word |
| txValid | output | 1 | txData is valid |
| txReady | input | 1 | Sink accepts txData this cycle |
| lkValid | input | 1 | Lookup request strobe |
| lkIp | input | 32 | IP address to resolve |
| lkDone | output | 1 | Lookup result valid (one cycle after lkValid) |
| lkHit | output | 1 | The looked-up IP is in the cache |
| lkMac | output | 48 | MAC of the cached IP (zero on a miss) |

## Verification
The bench keeps its own model of the cache and its round-robin pointer. After more than 16 distinct insertions it looks up every IP ever learned, so a pointer that advances on an in-place update, or that evicts the wrong slot, returns a wrong hit or MAC. A request with an odd byte count is followed at once by a second request. A parser that rounds the word count down would misread the second length word and lose the second reply. Short frames and frames that are ARP-like but wrong must stay silent and unlearned; a design that skips a field test would reply or learn. Two misses in quick succession must give exactly one broadcast request, and a reply sent while the sink stalls must arrive intact.

// File: rtl/arp_pkg.sv
package arp_pkg;
  localparam int WORD_W    = 16;
  localparam int CAP_WORDS = 21;  // data words holding the Ethernet header and the ARP body
  localparam int TX_WORDS  = 30;  // 60-byte minimum frame
  localparam int IDX_W     = 5;

  typedef struct packed {
    logic             capEn;
    logic [IDX_W-1:0] capIdx;
    logic             learnEn;
    logic             reqLatch;
    logic             txIsReply;
    logic [IDX_W-1:0] txIdx;
  } arpStrobe_t;
endpackage

// File: rtl/arp_ctrl.sv
module arp_ctrl
  import arp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic              txValid,
  input  logic              txReady,
  input  logic              lkMiss,
  input  logic              arpOk,
  input  logic              reqForUs,
  output arpStrobe_t        stb
);
  typedef enum logic [1:0] {ST_RX, ST_CHECK, ST_TX} state_t;
  localparam logic [IDX_W-1:0] IDX_SAT  = '1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TX_WORDS);
  localparam logic [IDX_W-1:0] IDX_MIN  = IDX_W'(CAP_WORDS);

  state_t state;
  logic inFrame, reqPending, txIsReply;
  logic [WORD_W-1:0] wordsLeft, wordsFromLen;
  logic [IDX_W-1:0] rxIdx, txIdx;
  logic rxFire, txFire, longEnough;

  assign rxReady      = (state == ST_RX) && (inFrame || !reqPending);
  assign txValid      = (state == ST_TX);
  assign rxFire       = rxValid && rxReady;
  assign txFire       = txValid && txReady;
  assign wordsFromLen = WORD_W'((17'(rxData) + 17'd1) >> 1);
  assign longEnough   = rxIdx >= IDX_MIN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RX;
      inFrame    <= 1'b0;
      wordsLeft  <= '0;
      rxIdx      <= '0;
      txIdx      <= '0;
      txIsReply  <= 1'b0;
      reqPending <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (rxFire) begin
            if (!inFrame) begin
              if (wordsFromLen != '0) begin
                inFrame   <= 1'b1;
                wordsLeft <= wordsFromLen;
                rxIdx     <= '0;
              end
            end else begin
              wordsLeft <= wordsLeft - 1'b1;
              if (rxIdx != IDX_SAT) rxIdx <= rxIdx + 1'b1;
              if (wordsLeft == 16'd1) begin
                inFrame <= 1'b0;
                state   <= ST_CHECK;
              end
            end
          end else if (!inFrame && reqPending) begin
            state     <= ST_TX;
            txIsReply <= 1'b0;
            txIdx     <= '0;
          end
        end
        ST_CHECK: begin
          if (longEnough && reqForUs) begin
            state     <= ST_TX;
            txIsReply <= 1'b1;
            txIdx     <= '0;
          end else begin
            state <= ST_RX;
          end
        end
        default: begin
          if (txFire) begin
            if (txIdx == IDX_LAST) begin
              state <= ST_RX;
              if (!txIsReply) reqPending <= 1'b0;
            end else begin
              txIdx <= txIdx + 1'b1;
            end
          end
        end
      endcase
      if (lkMiss && !reqPending) reqPending <= 1'b1;
    end
  end

  always_comb begin
    stb.capEn     = rxFire && inFrame;
    stb.capIdx    = rxIdx;
    stb.learnEn   = (state == ST_CHECK) && longEnough && arpOk;
    stb.reqLatch  = lkMiss && !reqPending;
    stb.txIsReply = txIsReply;
    stb.txIdx     = txIdx;
  end
endmodule

// File: rtl/arp_dpath.sv
module arp_dpath
  import arp_pkg::*;
#(
  parameter logic [47:0] LOCAL_MAC   = 48'h000102030405,
  parameter logic [31:0] LOCAL_IP    = 32'hC0A80101,
  parameter int          CACHE_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  arpStrobe_t        stb,
  input  logic [WORD_W-1:0] rxData,
  input  logic              lkValid,
  input  logic [31:0]       lkIp,
  output logic              lkDone,
  output logic              lkHit,
  output logic [47:0]       lkMac,
  output logic              lkMiss,
  output logic              arpOk,
  output logic              reqForUs,
  output logic [WORD_W-1:0] txData
);
  localparam int PTR_W = (CACHE_DEPTH > 1) ? $clog2(CACHE_DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(CACHE_DEPTH - 1);
  localparam logic [WORD_W-1:0] LEN_BYTES = WORD_W'(TX_WORDS * 2);

  // Received header and ARP body words
  logic [WORD_W-1:0] capW [CAP_WORDS];
  always_ff @(posedge clk) begin
    if (stb.capEn && (stb.capIdx < IDX_W'(CAP_WORDS))) capW[stb.capIdx] <= rxData;
  end

  logic [15:0] opCode;
  logic [47:0] sndMac;
  logic [31:0] sndIp, tgtIp;
  assign opCode   = capW[10];
  assign sndMac   = {capW[11], capW[12], capW[13]};
  assign sndIp    = {capW[14], capW[15]};
  assign tgtIp    = {capW[19], capW[20]};
  assign arpOk    = (capW[6] == 16'h0806) && (capW[7] == 16'h0001) && (capW[8] == 16'h0800) &&
                    (capW[9] == 16'h0604) && ((opCode == 16'd1) || (opCode == 16'd2));
  assign reqForUs = arpOk && (opCode == 16'd1) && (tgtIp == LOCAL_IP);

  // Address cache
  logic [CACHE_DEPTH-1:0] entV, learnMatch, lookMatch;
  logic [31:0] entIp  [CACHE_DEPTH];
  logic [47:0] entMac [CACHE_DEPTH];
  logic [PTR_W-1:0] rrPtr, learnIdx, lookIdx;

  generate
    for (genvar g = 0; g < CACHE_DEPTH; g++) begin : g_cmp
      assign learnMatch[g] = entV[g] && (entIp[g] == sndIp);
      assign lookMatch[g]  = entV[g] && (entIp[g] == lkIp);
    end
  endgenerate

  always_comb begin
    learnIdx = rrPtr;
    lookIdx  = '0;
    for (int i = 0; i < CACHE_DEPTH; i++) begin
      if (learnMatch[i]) learnIdx = PTR_W'(i);
      if (lookMatch[i])  lookIdx  = PTR_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entV  <= '0;
      rrPtr <= '0;
    end else if (stb.learnEn) begin
      entV[learnIdx] <= 1'b1;
      if (!(|learnMatch)) rrPtr <= (rrPtr == PTR_LAST) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.learnEn) begin
      entIp[learnIdx]  <= sndIp;
      entMac[learnIdx] <= sndMac;
    end
  end

  // Lookup port, one register stage
  logic [31:0] lkIpQ, reqIp;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkDone <= 1'b0;
      lkHit  <= 1'b0;
      lkMac  <= '0;
      lkIpQ  <= '0;
      reqIp  <= '0;
    end else begin
      lkDone <= lkValid;
      if (lkValid) begin
        lkHit <= |lookMatch;
        lkMac <= (|lookMatch) ? entMac[lookIdx] : '0;
        lkIpQ <= lkIp;
      end
      if (stb.reqLatch) reqIp <= lkIpQ;
    end
  end
  assign lkMiss = lkDone && !lkHit;

  // Outgoing frame word select
  always_comb begin
    case (stb.txIdx)
      5'd0:  txData = LEN_BYTES;
      5'd1:  txData = stb.txIsReply ? capW[11] : 16'hFFFF;
      5'd2:  txData = stb.txIsReply ? capW[12] : 16'hFFFF;
      5'd3:  txData = stb.txIsReply ? capW[13] : 16'hFFFF;
      5'd4, 5'd12: txData = LOCAL_MAC[47:32];
      5'd5, 5'd13: txData = LOCAL_MAC[31:16];
      5'd6, 5'd14: txData = LOCAL_MAC[15:0];
      5'd7:  txData = 16'h0806;
      5'd8:  txData = 16'h0001;
      5'd9:  txData = 16'h0800;
      5'd10: txData = 16'h0604;
      5'd11: txData = stb.txIsReply ? 16'd2 : 16'd1;
      5'd15: txData = LOCAL_IP[31:16];
      5'd16: txData = LOCAL_IP[15:0];
      5'd17: txData = stb.txIsReply ? capW[11] : 16'h0000;
      5'd18: txData = stb.txIsReply ? capW[12] : 16'h0000;
      5'd19: txData = stb.txIsReply ? capW[13] : 16'h0000;
      5'd20: txData = stb.txIsReply ? capW[14] : reqIp[31:16];
      5'd21: txData = stb.txIsReply ? capW[15] : reqIp[15:0];
      default: txData = 16'h0000;
    endcase
  end
endmodule

// File: rtl/arp_responder.sv
module arp_responder
  import arp_pkg::*;
#(
  parameter logic [47:0] LOCAL_MAC   = 48'h000102030405,
  parameter logic [31:0] LOCAL_IP    = 32'hC0A80101,
  parameter int          CACHE_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] rxData,
  input  logic        rxValid,
  output logic        rxReady,
  output logic [15:0] txData,
  output logic        txValid,
  input  logic        txReady,
  input  logic        lkValid,
  input  logic [31:0] lkIp,
  output logic        lkDone,
  output logic        lkHit,
  output logic [47:0] lkMac
);
  arpStrobe_t stb;
  logic lkMiss, arpOk, reqForUs;

  arp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txValid(txValid), .txReady(txReady), .lkMiss(lkMiss), .arpOk(arpOk),
    .reqForUs(reqForUs), .stb(stb)
  );

  arp_dpath #(.LOCAL_MAC(LOCAL_MAC), .LOCAL_IP(LOCAL_IP), .CACHE_DEPTH(CACHE_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .rxData(rxData), .lkValid(lkValid), .lkIp(lkIp),
    .lkDone(lkDone), .lkHit(lkHit), .lkMac(lkMac), .lkMiss(lkMiss), .arpOk(arpOk),
    .reqForUs(reqForUs), .txData(txData)
  );
endmodule

// File: rtl/arp_responder_chk.sv
module arp_responder_chk
  import arp_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        rxReady,
  input logic        txValid,
  input logic        txReady,
  input logic [15:0] txData,
  input logic        lkValid,
  input logic        lkDone
);
  logic [IDX_W-1:0] beat;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) beat <= '0;
    else if (txValid && txReady) beat <= (beat == IDX_W'(TX_WORDS)) ? '0 : beat + 1'b1;
  end

  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));
  a_r11_rx_blocked: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !rxReady);
  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> lkDone);
  a_r6_no_stray_done: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !lkDone);
  a_r1_length_word: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && beat == '0) |-> (txData == 16'(TX_WORDS * 2)));
endmodule

bind arp_responder arp_responder_chk u_chk (
  .clk(clk), .rstN(rstN), .rxReady(rxReady), .txValid(txValid), .txReady(txReady),
  .txData(txData), .lkValid(lkValid), .lkDone(lkDone)
);

// File: tb/arp_responder_bench.sv
module arp_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] MY_MAC = 48'h000102030405;
  localparam logic [31:0] MY_IP  = 32'hC0A80101;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] rxData = '0;
  logic rxValid = 1'b0, rxReady, txValid, txReady = 1'b0;
  logic [15:0] txData;
  logic lkValid = 1'b0, lkDone, lkHit;
  logic [31:0] lkIp = '0;
  logic [47:0] lkMac;

  arp_responder u_arp_responder (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady), .lkValid(lkValid),
    .lkIp(lkIp), .lkDone(lkDone), .lkHit(lkHit), .lkMac(lkMac)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nTests = 0, nFail = 0;
  bit finished = 1'b0;
  bit stallMode = 1'b0;
  int unsigned cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    txReady <= !stallMode || (cyc % 3 == 0);
  end

  logic [15:0] cap [0:255];
  int capCount = 0, rxDuringTx = 0;
  always @(negedge clk) begin
    if (rstN && txValid && txReady) begin
      if (capCount < 256) cap[capCount] = txData;
      capCount++;
    end
    if (rstN && txValid && rxReady) rxDuringTx++;
  end

  // Cache model
  logic [31:0] mIp [16];
  logic [47:0] mMac [16];
  bit mV [16];
  int mPtr = 0;

  task automatic mdlLearn(input logic [31:0] ip, input logic [47:0] mac);
    for (int i = 0; i < 16; i++) begin
      if (mV[i] && mIp[i] == ip) begin
        mMac[i] = mac;
        return;
      end
    end
    mV[mPtr] = 1'b1; mIp[mPtr] = ip; mMac[mPtr] = mac;
    mPtr = (mPtr + 1) % 16;
  endtask

  task automatic mdlFind(input logic [31:0] ip, output bit hit, output logic [47:0] mac);
    hit = 1'b0; mac = '0;
    for (int i = 0; i < 16; i++) if (mV[i] && mIp[i] == ip) begin hit = 1'b1; mac = mMac[i]; end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic putWord(input logic [15:0] w);
    @(negedge clk);
    rxValid = 1'b1; rxData = w;
    while (!rxReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic sendArp(input int len, input logic [15:0] etype, input logic [15:0] htype,
                         input logic [15:0] op, input logic [47:0] sMac,
                         input logic [31:0] sIp, input logic [31:0] tIp);
    logic [15:0] frm [0:29];
    for (int i = 0; i < 30; i++) frm[i] = 16'h0000;
    for (int i = 0; i < 3; i++) begin
      frm[i] = 16'hFFFF;
      frm[3+i]  = sMac[47-16*i -: 16];
      frm[11+i] = sMac[47-16*i -: 16];
    end
    frm[6] = etype; frm[7] = htype; frm[8] = 16'h0800; frm[9] = 16'h0604; frm[10] = op;
    frm[14] = sIp[31:16]; frm[15] = sIp[15:0];
    frm[19] = tIp[31:16]; frm[20] = tIp[15:0];
    putWord(16'(len));
    for (int i = 0; i < (len + 1) / 2; i++) putWord((i < 30) ? frm[i] : 16'h0000);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // Compares one captured 31-word frame with the expected reply or request
  task automatic checkFrame(input int base, input bit isReply, input logic [47:0] peerMac,
                            input logic [31:0] peerIp, input string req);
    logic [15:0] exp [0:30];
    int bad;
    for (int i = 0; i < 31; i++) exp[i] = 16'h0000;
    exp[0] = 16'd60;
    for (int i = 0; i < 3; i++) begin
      exp[1+i]  = isReply ? peerMac[47-16*i -: 16] : 16'hFFFF;
      exp[4+i]  = MY_MAC[47-16*i -: 16];
      exp[12+i] = MY_MAC[47-16*i -: 16];
      exp[17+i] = isReply ? peerMac[47-16*i -: 16] : 16'h0000;
    end
    exp[7] = 16'h0806; exp[8] = 16'h0001; exp[9] = 16'h0800; exp[10] = 16'h0604;
    exp[11] = isReply ? 16'd2 : 16'd1;
    exp[15] = MY_IP[31:16]; exp[16] = MY_IP[15:0];
    exp[20] = peerIp[31:16]; exp[21] = peerIp[15:0];
    bad = -1;
    for (int i = 30; i >= 0; i--) if (cap[base+i] !== exp[i]) bad = i;
    if (bad < 0) check(1'b1, req, "frame", 0, 0);
    else check(1'b0, req, $sformatf("frame word %0d", bad), 64'(cap[base+bad]), 64'(exp[bad]));
  endtask

  task automatic doLookup(input logic [31:0] ip, input string req);
    bit eHit;
    logic [47:0] eMac;
    mdlFind(ip, eHit, eMac);
    @(negedge clk);
    lkValid = 1'b1; lkIp = ip;
    @(negedge clk);
    lkValid = 1'b0;
    check(lkDone && (lkHit == eHit) && (!eHit || lkMac == eMac), req,
          $sformatf("lookup %h done/hit/mac", ip), {lkDone, lkHit, 14'd0, lkMac},
          {1'b1, eHit, 14'd0, eMac});
  endtask

  localparam logic [47:0] MAC_H = 48'h0A0B0C0D0E0F;
  localparam logic [31:0] IP_H  = 32'hC0A80107;

  initial begin
    int base;
    for (int i = 0; i < 16; i++) mV[i] = 1'b0;
    waitCycles(3);
    rstN = 1'b1;
    @(negedge clk);

    // R12: reset state
    check(!txValid, "R12", "txValid after reset", 64'(txValid), 0);
    check(rxReady, "R12", "rxReady after reset", 64'(rxReady), 1);
    check(!lkDone, "R12", "lkDone after reset", 64'(lkDone), 0);

    // R12/R9/R10: empty cache misses, one request, second miss dropped
    base = capCount;
    doLookup(32'hC0A80163, "R12");
    doLookup(32'hC0A80164, "R10");
    waitCycles(60);
    check(capCount - base == 31, "R10", "words after two misses", 64'(capCount - base), 31);
    checkFrame(base, 1'b0, 48'h0, 32'hC0A80163, "R9");

    // R1/R11: request for local IP with a stalling sink
    stallMode = 1'b1;
    base = capCount;
    sendArp(42, 16'h0806, 16'h0001, 16'd1, MAC_H, IP_H, MY_IP);
    mdlLearn(IP_H, MAC_H);
    waitCycles(150);
    check(capCount - base == 31, "R1", "reply word count", 64'(capCount - base), 31);
    checkFrame(base, 1'b1, MAC_H, IP_H, "R1");
    stallMode = 1'b0;

    // R5/R6: learned pair visible, done lasts one cycle
    doLookup(IP_H, "R5");
    @(negedge clk);
    check(!lkDone, "R6", "lkDone second cycle", 64'(lkDone), 0);

    // R2: frames that fail a field test
    base = capCount;
    sendArp(42, 16'h0800, 16'h0001, 16'd1, 48'h111111111111, 32'h0A010101, MY_IP);
    sendArp(42, 16'h0806, 16'h0001, 16'd1, 48'h222222222222, 32'h0A010102, 32'hC0A80199);
    mdlLearn(32'h0A010102, 48'h222222222222);
    sendArp(42, 16'h0806, 16'h0001, 16'd2, 48'h333333333333, 32'h0A010103, MY_IP);
    mdlLearn(32'h0A010103, 48'h333333333333);
    sendArp(42, 16'h0806, 16'h0006, 16'd1, 48'h444444444444, 32'h0A010104, MY_IP);
    waitCycles(60);
    check(capCount == base, "R2", "output words for non-matching frames", 64'(capCount - base), 0);
    doLookup(32'h0A010101, "R2");
    doLookup(32'h0A010102, "R5");
    doLookup(32'h0A010103, "R5");
    doLookup(32'h0A010104, "R2");
    waitCycles(80);

    // R3: odd length followed at once by a second request
    base = capCount;
    sendArp(43, 16'h0806, 16'h0001, 16'd1, 48'h5A5A5A5A5A01, 32'hC0A80121, MY_IP);
    mdlLearn(32'hC0A80121, 48'h5A5A5A5A5A01);
    sendArp(42, 16'h0806, 16'h0001, 16'd1, 48'h5A5A5A5A5A02, 32'hC0A80122, MY_IP);
    mdlLearn(32'hC0A80122, 48'h5A5A5A5A5A02);
    waitCycles(150);
    check(capCount - base == 62, "R3", "words for two replies", 64'(capCount - base), 62);
    checkFrame(base, 1'b1, 48'h5A5A5A5A5A01, 32'hC0A80121, "R3");
    checkFrame(base + 31, 1'b1, 48'h5A5A5A5A5A02, 32'hC0A80122, "R3");

    // R4: short frame
    base = capCount;
    sendArp(40, 16'h0806, 16'h0001, 16'd1, 48'h666666666666, 32'hC0A80130, MY_IP);
    waitCycles(60);
    check(capCount == base, "R4", "reply to short frame", 64'(capCount - base), 0);
    doLookup(32'hC0A80130, "R4");
    waitCycles(80);

    // R7: in-place update
    sendArp(42, 16'h0806, 16'h0001, 16'd2, 48'h777777777777, IP_H, 32'hC0A80199);
    mdlLearn(IP_H, 48'h777777777777);
    waitCycles(20);
    doLookup(IP_H, "R7");
    waitCycles(80);

    // R8: sweep past the cache size, then look up every IP ever learned
    for (int i = 0; i < 20; i++) begin
      sendArp(42, 16'h0806, 16'h0001, 16'd2, 48'hB00000000000 + 48'(i),
              32'h0A000000 + 32'(i), 32'h0A0000FF);
      mdlLearn(32'h0A000000 + 32'(i), 48'hB00000000000 + 48'(i));
    end
    waitCycles(20);
    for (int i = 0; i < 20; i++) doLookup(32'h0A000000 + 32'(i), "R8");
    doLookup(IP_H, "R8");
    doLookup(32'h0A010102, "R8");
    doLookup(32'hC0A80122, "R8");
    waitCycles(80);

    check(rxDuringTx == 0, "R11", "cycles with rxReady during tx", 64'(rxDuringTx), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule